// File: doc/BRIEF.md
# Multi-Port Bank Access Controller

This block sits between four two-wire serial slave ports and three 256-byte memory banks numbered 1 to 3. The serial protocol engines for each port report START and STOP conditions, a completed slave address byte and every later byte boundary. The controller answers with one acknowledge decision per port, a bank index for each port, and a write-enable flag. The memory array, the serial shifters and the nonvolatile write timing are handled outside.

Port 0 is the host port: it can read or write any bank and chooses the bank through the two low select bits of the slave address. Ports 1 to 3 are read-only display ports, each tied to the bank with its own number. A single write-protect level decides which side is served: high serves only the host port, low serves only the display ports, and the display ports then run independently of each other. The level is sampled at every START. If it moves while a transaction is open, the next acknowledge slot on that port is withheld and the transaction is dropped.

Top module: `bank_access_ctrl`

## Requirements
- R1: After reset every acknowledge, accept, write-enable and bank output is 0.
- R2: A slave address byte is laid out as device type in bits 7:4, select field in bits 3:1 and direction in bit 0 (1 = read, 0 = write). A device type other than 4'b1010 is never acknowledged on any port.
- R3: With write-protect high, port 0 acknowledges select values 3'b001, 3'b010 and 3'b011, and its bank output then reads 1, 2 and 3 respectively.
- R4: Port 0 does not acknowledge select value 3'b000 or any select value with bit 2 set.
- R5: With write-protect low, port N (N = 1..3) acknowledges only select value 3'b000 and its bank output then reads N; any other select value is not acknowledged.
- R6: With write-protect high, ports 1 to 3 acknowledge nothing; with write-protect low, port 0 acknowledges nothing.
- R7: Write enable is raised only on port 0, and only while its transaction is accepted with direction bit 0; ports 1 to 3 never raise it, even for a write-direction address.
- R8: Write-protect is sampled at START; if its level at the address byte differs from the sampled level, the address is not acknowledged.
- R9: If write-protect changes during an accepted transaction, the next byte boundary on that port gets no acknowledge and the accept and write-enable flags of that port drop.
- R10: Ports 1 to 3 may be addressed in the same cycle; each acknowledges and reports its own bank.
- R11: An acknowledge is a single-cycle pulse in the cycle after the address-valid or byte-end strobe; while a transaction stays accepted and write-protect is stable, every byte boundary is acknowledged.
- R12: A STOP on a port clears that port's accept and write-enable flags in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_i | input | 1 | Write-protect level, already synchronized |
| start_i | input | NPORTS | One-cycle START strobe per port |
| stop_i | input | NPORTS | One-cycle STOP strobe per port |
| addr_vld_i | input | NPORTS | Slave address byte complete, per port |
| addr_byte_i | input | NPORTS*8 | Slave address byte per port, port p in bits 8p+7:8p |
| byte_end_i | input | NPORTS | Later byte complete, acknowledge slot due |
| ack_o | output | NPORTS | Acknowledge decision pulse per port |
| acc_o | output | NPORTS | Transaction accepted, per port |
| bank_o | output | NPORTS*BANKW | Bank index per port, port p in bits BANKW*p+BANKW-1:BANKW*p |
| wr_en_o | output | NPORTS | Write permission per port |

## Verification
The bench builds the block with its default of four ports, which gives a two-bit bank index and the full set of three banks, so the host's top select code 3'b011 and every display port's own bank are reachable. The fixed device type 4'b1010 is used, so a one-bit change in the type nibble is a reachable rejection case. With three display ports the bench can strobe them together and see each hold a distinct bank while the host is shut out.

// File: rtl/bacc_pkg.sv
package bacc_pkg;
   localparam logic [3:0] DEV_TYPE_DEFAULT = 4'b1010;

   typedef struct packed {
      logic [3:0] dtype;
      logic [2:0] sel;
      logic       rd;
   } slv_addr_t;
endpackage

// File: rtl/bacc_sel_decode.sv
module bacc_sel_decode #(
   parameter int PORT_ID = 0,
   parameter int NPORTS  = 4,
   localparam int BANKW  = $clog2(NPORTS)
) (
   input  logic [2:0]       sel_i,
   output logic             ok_o,
   output logic [BANKW-1:0] bank_o
);
   generate
      if (PORT_ID == 0) begin : g_host
         // host picks a bank through the select field; zero names none
         always_comb begin
            ok_o   = (sel_i != 3'd0) && (int'(sel_i) < NPORTS);
            bank_o = sel_i[BANKW-1:0];
         end
      end else begin : g_disp
         // display port: fixed bank, select field must be clear
         always_comb begin
            ok_o   = (sel_i == 3'd0);
            bank_o = BANKW'(PORT_ID);
         end
      end
   endgenerate
endmodule

// File: rtl/bacc_port.sv
module bacc_port
   import bacc_pkg::*;
#(
   parameter int          PORT_ID  = 0,
   parameter int          NPORTS   = 4,
   parameter logic [3:0]  DEV_TYPE = DEV_TYPE_DEFAULT,
   localparam int         BANKW    = $clog2(NPORTS),
   localparam bit         IS_HOST  = (PORT_ID == 0)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wp_i,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             addr_vld_i,
   input  logic [7:0]       addr_byte_i,
   input  logic             byte_end_i,
   output logic             ack_o,
   output logic             acc_o,
   output logic [BANKW-1:0] bank_o,
   output logic             wr_en_o
);
   slv_addr_t        a;
   logic             open_q, snap_q, moved_q, wmode_q;
   logic             dec_ok, bad, role_ok, hit;
   logic [BANKW-1:0] dec_bank;

   assign a = slv_addr_t'(addr_byte_i);

   bacc_sel_decode #(.PORT_ID(PORT_ID), .NPORTS(NPORTS)) u_dec (
      .sel_i (a.sel),
      .ok_o  (dec_ok),
      .bank_o(dec_bank)
   );

   always_comb begin
      bad     = moved_q || (wp_i != snap_q);
      role_ok = IS_HOST ? snap_q : !snap_q;
      hit     = (a.dtype == DEV_TYPE) && dec_ok && role_ok && !bad;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q  <= 1'b0;
         snap_q  <= 1'b0;
         moved_q <= 1'b0;
         wmode_q <= 1'b0;
         acc_o   <= 1'b0;
         ack_o   <= 1'b0;
         bank_o  <= '0;
      end else begin
         ack_o <= 1'b0;
         if (start_i) begin
            open_q  <= 1'b1;
            snap_q  <= wp_i;
            moved_q <= 1'b0;
            acc_o   <= 1'b0;
            wmode_q <= 1'b0;
         end else if (stop_i) begin
            open_q  <= 1'b0;
            moved_q <= 1'b0;
            acc_o   <= 1'b0;
            wmode_q <= 1'b0;
         end else begin
            if (open_q && (wp_i != snap_q)) moved_q <= 1'b1;
            if (addr_vld_i && open_q) begin
               acc_o   <= hit;
               ack_o   <= hit;
               wmode_q <= hit && IS_HOST && !a.rd;
               if (hit) bank_o <= dec_bank;
            end else if (byte_end_i && acc_o) begin
               ack_o <= !bad;
               if (bad) begin
                  acc_o   <= 1'b0;
                  wmode_q <= 1'b0;
               end
            end
         end
      end
   end

   generate
      if (IS_HOST) begin : g_wen
         assign wr_en_o = acc_o && wmode_q;
      end else begin : g_nowen
         assign wr_en_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/bank_access_ctrl.sv
module bank_access_ctrl
   import bacc_pkg::*;
#(
   parameter int         NPORTS   = 4,
   parameter logic [3:0] DEV_TYPE = DEV_TYPE_DEFAULT,
   localparam int        BANKW    = $clog2(NPORTS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wp_i,
   input  logic [NPORTS-1:0]       start_i,
   input  logic [NPORTS-1:0]       stop_i,
   input  logic [NPORTS-1:0]       addr_vld_i,
   input  logic [NPORTS*8-1:0]     addr_byte_i,
   input  logic [NPORTS-1:0]       byte_end_i,
   output logic [NPORTS-1:0]       ack_o,
   output logic [NPORTS-1:0]       acc_o,
   output logic [NPORTS*BANKW-1:0] bank_o,
   output logic [NPORTS-1:0]       wr_en_o
);
   initial begin
      if (NPORTS < 2 || NPORTS > 4)
         $error("bank_access_ctrl: NPORTS must lie in 2..4, select field is 3 bits");
   end

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      bacc_port #(.PORT_ID(p), .NPORTS(NPORTS), .DEV_TYPE(DEV_TYPE)) u_port (
         .clk        (clk),
         .rst_n      (rst_n),
         .wp_i       (wp_i),
         .start_i    (start_i[p]),
         .stop_i     (stop_i[p]),
         .addr_vld_i (addr_vld_i[p]),
         .addr_byte_i(addr_byte_i[p*8 +: 8]),
         .byte_end_i (byte_end_i[p]),
         .ack_o      (ack_o[p]),
         .acc_o      (acc_o[p]),
         .bank_o     (bank_o[p*BANKW +: BANKW]),
         .wr_en_o    (wr_en_o[p])
      );
   end
endmodule

// File: rtl/bacc_checker.sv
module bacc_checker #(
   parameter int  NPORTS = 4,
   localparam int BANKW  = $clog2(NPORTS)
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [NPORTS-1:0]       stop_i,
   input logic [NPORTS-1:0]       start_i,
   input logic [NPORTS-1:0]       addr_vld_i,
   input logic [NPORTS-1:0]       byte_end_i,
   input logic [NPORTS-1:0]       ack_o,
   input logic [NPORTS-1:0]       acc_o,
   input logic [NPORTS*BANKW-1:0] bank_o,
   input logic [NPORTS-1:0]       wr_en_o
);
   p_wren_host_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o[NPORTS-1:1] == '0);

   p_wren_needs_acc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o[0] |-> acc_o[0]);

   p_ack_follows_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (|ack_o) |-> ((ack_o & ~$past(addr_vld_i | byte_end_i)) == '0));

   p_side_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(ack_o[0] && (|ack_o[NPORTS-1:1])));

   p_stop_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (|(stop_i & ~start_i)) |=> ((acc_o & $past(stop_i & ~start_i)) == '0));

   p_host_bank_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      acc_o[0] |-> (bank_o[BANKW-1:0] != '0));
endmodule

bind bank_access_ctrl bacc_checker #(.NPORTS(NPORTS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .stop_i    (stop_i),
   .start_i   (start_i),
   .addr_vld_i(addr_vld_i),
   .byte_end_i(byte_end_i),
   .ack_o     (ack_o),
   .acc_o     (acc_o),
   .bank_o    (bank_o),
   .wr_en_o   (wr_en_o)
);

// File: tb/sim_bank_access_ctrl.sv
module sim_bank_access_ctrl;
   localparam int NP = 4;
   localparam int BW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wp = 1'b0;
   logic [NP-1:0] start = '0, stop = '0, avld = '0, bend = '0;
   logic [NP*8-1:0] abyte = '0;
   logic [NP-1:0] ack, acc, wen;
   logic [NP*BW-1:0] bank;

   int n_chk = 0, n_fail = 0;

   always #2 clk = ~clk;

   bank_access_ctrl #(.NPORTS(NP)) u0 (
      .clk(clk), .rst_n(rst_n), .wp_i(wp),
      .start_i(start), .stop_i(stop), .addr_vld_i(avld),
      .addr_byte_i(abyte), .byte_end_i(bend),
      .ack_o(ack), .acc_o(acc), .bank_o(bank), .wr_en_o(wen)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic expect_eq(input string tag, input int act, input int exp);
      chk(act == exp, tag, act, exp);
   endtask

   task automatic do_start(input logic [NP-1:0] m);
      start = m; @(negedge clk); start = '0;
   endtask

   task automatic do_stop(input logic [NP-1:0] m);
      stop = m; @(negedge clk); stop = '0;
   endtask

   task automatic do_addr(input logic [NP-1:0] m, input logic [7:0] b);
      for (int p = 0; p < NP; p++) abyte[p*8 +: 8] = b;
      avld = m; @(negedge clk); avld = '0;
   endtask

   task automatic do_byte(input logic [NP-1:0] m);
      bend = m; @(negedge clk); bend = '0;
   endtask

   function automatic int bank_of(input int p);
      return int'(bank[p*BW +: BW]);
   endfunction

   task automatic t_reset;
      expect_eq("R1 ack", int'(ack), 0);
      expect_eq("R1 acc", int'(acc), 0);
      expect_eq("R1 wen", int'(wen), 0);
      expect_eq("R1 bank", int'(bank), 0);
   endtask

   task automatic t_host_banks;
      wp = 1'b1;
      for (int s = 1; s <= 3; s++) begin
         do_start(4'b0001);
         do_addr(4'b0001, {4'b1010, 3'(s), 1'b0});
         expect_eq("R3 ack", int'(ack), 1);
         expect_eq("R3 bank", bank_of(0), s);
         expect_eq("R7 host write wen", int'(wen), 1);
         @(negedge clk);
         expect_eq("R11 ack single pulse", int'(ack), 0);
         do_byte(4'b0001);
         expect_eq("R11 data ack", int'(ack), 1);
         do_stop(4'b0001);
         expect_eq("R12 acc after stop", int'(acc), 0);
         expect_eq("R12 wen after stop", int'(wen), 0);
      end
      do_start(4'b0001);
      do_addr(4'b0001, 8'hA7);
      expect_eq("R3 read ack", int'(ack), 1);
      expect_eq("R7 host read no wen", int'(wen), 0);
      do_stop(4'b0001);
   endtask

   task automatic t_host_reject;
      wp = 1'b1;
      do_start(4'b0001);
      do_addr(4'b0001, 8'hA0);
      expect_eq("R4 select 000", int'(ack), 0);
      expect_eq("R4 no acc", int'(acc), 0);
      do_start(4'b0001);
      do_addr(4'b0001, 8'hAA);
      expect_eq("R4 select 101", int'(ack), 0);
      do_start(4'b0001);
      do_addr(4'b0001, 8'hB2);
      expect_eq("R2 type 1011 host", int'(ack), 0);
      do_stop(4'b0001);
      wp = 1'b0;
      do_start(4'b0001);
      do_addr(4'b0001, 8'hA2);
      expect_eq("R6 host with wp low", int'(ack), 0);
      do_stop(4'b0001);
   endtask

   task automatic t_display;
      wp = 1'b0;
      do_start(4'b1110);
      do_addr(4'b1110, 8'hA1);
      expect_eq("R10 all display ack", int'(ack), 14);
      expect_eq("R5 bank port1", bank_of(1), 1);
      expect_eq("R5 bank port2", bank_of(2), 2);
      expect_eq("R5 bank port3", bank_of(3), 3);
      do_stop(4'b1110);
      do_start(4'b0010);
      do_addr(4'b0010, 8'hA0);
      expect_eq("R7 display write addr ack", int'(ack), 2);
      expect_eq("R7 display no wen", int'(wen), 0);
      do_start(4'b0100);
      do_addr(4'b0100, 8'hA3);
      expect_eq("R5 nonzero select", int'(ack), 0);
      do_start(4'b1000);
      do_addr(4'b1000, 8'hE1);
      expect_eq("R2 type 1110 display", int'(ack), 0);
      do_stop(4'b1110);
      wp = 1'b1;
      do_start(4'b1110);
      do_addr(4'b1110, 8'hA1);
      expect_eq("R6 display with wp high", int'(ack), 0);
      do_stop(4'b1110);
   endtask

   task automatic t_wp_sample;
      wp = 1'b1;
      do_start(4'b0001);
      wp = 1'b0;
      @(negedge clk);
      wp = 1'b1;
      do_addr(4'b0001, 8'hA2);
      expect_eq("R8 host wp moved before addr", int'(ack), 0);
      do_stop(4'b0001);
      wp = 1'b1;
      do_start(4'b0010);
      wp = 1'b0;
      do_addr(4'b0010, 8'hA1);
      expect_eq("R8 display snapped high", int'(ack), 0);
      do_stop(4'b0010);
   endtask

   task automatic t_wp_abort;
      wp = 1'b1;
      do_start(4'b0001);
      do_addr(4'b0001, 8'hA4);
      expect_eq("R9 setup ack", int'(ack), 1);
      wp = 1'b0;
      @(negedge clk);
      expect_eq("R9 wen held until boundary", int'(wen), 1);
      do_byte(4'b0001);
      expect_eq("R9 boundary ack withheld", int'(ack), 0);
      expect_eq("R9 acc dropped", int'(acc), 0);
      expect_eq("R9 wen dropped", int'(wen), 0);
      do_stop(4'b0001);
      do_start(4'b0100);
      do_addr(4'b0100, 8'hA1);
      wp = 1'b1;
      do_byte(4'b0100);
      expect_eq("R9 display abort", int'(ack), 0);
      do_stop(4'b0100);
   endtask

   initial begin : watchdog
      #400000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_host_banks();
      t_host_reject();
      t_display();
      t_wp_sample();
      t_wp_abort();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule